// File: doc/BRIEF.md
# SPI DAC Register Slave Interface

This block is the digital front end of a four-channel converter. A host talks to it over a four-wire serial link: an active-low frame select, a serial clock, a data input and a three-state data output. Each frame carries sixteen bits, most significant first. The first bit picks read or write, the next three pick a target, and the last twelve carry the data. A write updates one channel input register, all four channel registers at once, or the control register. A read returns the addressed register on the data output within the same frame.

The serial pins are brought into the system clock domain through synchronizers. The clock edges are then found by comparing each sample with the one before. The stored registers are presented as parallel outputs. Each update comes with a one-cycle write strobe for the neighbouring latch and power logic. The output driver enable is a separate port, so the pad three-state buffer sits outside the block.

Top module: `spi_dac_regif`

## Requirements
- R1: A frame is sixteen bits, sampled on rising serial-clock edges after frame select falls, most significant first. Bit 15 is the direction (0 write, 1 read), bits 14:12 are the address, and bits 11:0 are the data.
- R2: A command takes effect at the sixteenth falling serial-clock edge of its frame. It does not wait for frame select to rise.
- R3: A write to address 1, 2, 3 or 4 loads the data into channel A, B, C or D. It raises exactly that channel's bit of `ch_wr_stb` (bit address−1) for one clock.
- R4: A write to address 5 loads the same data into all four channels and raises all four strobe bits in the same clock.
- R5: A write to address 7 sets the per-channel power-up flags from data bits 5:2 (bit 2 is channel A) and the output-float flag from data bit 6, with one `ctrl_wr_stb` pulse. A read of address 7 returns those flags at the same bit positions and zeros in all other bits.
- R6: A write to address 0 or address 6 changes no register and raises no strobe.
- R7: If frame select rises before the sixteenth falling edge, the partial frame is dropped. No register changes and no strobe fires.
- R8: In a read frame, `spi_miso_oe` goes high at the fifth rising edge. The twelve register bits then appear MSB first, each one updated on a rising edge (bit 11 at clock 5, bit 0 at clock 16). A read changes no register and fires no strobe.
- R9: `spi_miso_oe` stays low throughout a write frame and while frame select is high. It drops after the sixteenth falling edge of a read frame.
- R10: Reads of address 0, 5 or 6 return twelve zero bits.
- R11: Once a frame has completed, further serial clocks with frame select still low are ignored. A new frame starts only after frame select goes high and then falls again.
- R12: After reset, all channel registers, control flags and strobes are zero and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data |
| spi_miso_oe | output | 1 | Drive enable for the read data pad |
| ch_data | output | NCH*DATA_W | Channel input registers, channel A in the lowest bits |
| ch_wr_stb | output | NCH | One-cycle update pulse per channel |
| ctrl_pwr_up | output | NCH | Per-channel power-up flags, bit 0 is channel A |
| ctrl_out_hiz | output | 1 | Output-float flag |
| ctrl_wr_stb | output | 1 | One-cycle control register update pulse |

## Verification
Two events share the same clock cycle: the execution pulse at the sixteenth falling edge, and the release of the read-data enable. Frame select rising also lands close to that final edge. The bench provokes both orderings. In one frame, select rises half a serial period before the last falling edge, and the bench expects the frame to be dropped. In another, select stays low past that edge, and the bench expects the channel to be updated while select is still low, then sends a whole extra frame that must be ignored. Broadcast writes make all four channel strobes fire together. The bench judges each case by per-channel strobe pulse counts and by the parallel register outputs.

// File: rtl/spi_dac_pkg.sv
package spi_dac_pkg;
  localparam int unsigned DEF_NCH     = 4;
  localparam int unsigned DEF_ADDR_W  = 3;
  localparam int unsigned DEF_DATA_W  = 12;
  localparam int unsigned DEF_SYNC    = 2;
  // first data bit of the per-channel power-up field in the control word
  localparam int unsigned CTRL_PWR_LSB = 2;
endpackage

// File: rtl/spi_dac_sync.sv
module spi_dac_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[g]}};
      else     pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_dac_frame.sv
module spi_dac_frame #(
  parameter int unsigned ADDR_W = spi_dac_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = spi_dac_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              exec,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int unsigned HDR_W   = 1 + ADDR_W;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d, cs_d;
  logic               armed, done;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [DATA_W-1:0]  rd_sh;

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire cs_fall   = cs_d & ~cs_n_s;
  wire live      = armed & ~done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      armed  <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      rd_sh  <= '0;
      sdo_en <= 1'b0;
      exec   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      exec   <= 1'b0;
      if (cs_n_s) begin
        armed  <= 1'b0;
        done   <= 1'b0;
        cnt    <= '0;
        sdo_en <= 1'b0;
      end else if (cs_fall) begin
        armed <= 1'b1;
        done  <= 1'b0;
        cnt   <= '0;
      end else if (live) begin
        if (sclk_rise && cnt < CNT_FULL) begin
          sh  <= {sh[FRAME_W-2:0], mosi_s};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_HDR && sh[HDR_W-1]) begin
            sdo_en <= 1'b1;
            rd_sh  <= rd_word;
          end else if (cnt > CNT_HDR) begin
            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
          end
        end
        if (sclk_fall && cnt == CNT_FULL) begin
          exec   <= 1'b1;
          done   <= 1'b1;
          sdo_en <= 1'b0;
        end
      end
    end
  end

  assign rd_addr  = sh[ADDR_W-1:0];
  assign cmd_rd   = sh[FRAME_W-1];
  assign cmd_addr = sh[FRAME_W-2 -: ADDR_W];
  assign cmd_data = sh[DATA_W-1:0];
  assign sdo      = rd_sh[DATA_W-1];

  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
  a_r2_exec_single: assert property (@(posedge clk) disable iff (rst)
    exec |=> !exec);
  a_r8_oe_at_fifth: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> (cnt == CNT_HDR + 1'b1 && sh[HDR_W]));
  a_r9_oe_drops_on_cs: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !sdo_en);
  a_r7_no_exec_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && $past(cs_n_s)) |-> !exec);
endmodule

// File: rtl/spi_dac_regs.sv
module spi_dac_regs #(
  parameter int unsigned NCH    = spi_dac_pkg::DEF_NCH,
  parameter int unsigned ADDR_W = spi_dac_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = spi_dac_pkg::DEF_DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  exec,
  input  logic                  cmd_rd,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_word,
  output logic [NCH*DATA_W-1:0] ch_flat,
  output logic [NCH-1:0]        wr_stb,
  output logic [NCH-1:0]        pwr_q,
  output logic                  hiz_q,
  output logic                  ctrl_stb
);
  localparam int unsigned PWR_LSB = spi_dac_pkg::CTRL_PWR_LSB;
  localparam int unsigned HIZ_BIT = PWR_LSB + NCH;
  localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = {ADDR_W{1'b1}};

  logic [DATA_W-1:0] ch_q [NCH];
  wire wr_cmd = exec & ~cmd_rd;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(g + 1);
    wire hit = wr_cmd && (cmd_addr == A_ME || cmd_addr == A_ALL);
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_q[g]   <= '0;
        wr_stb[g] <= 1'b0;
      end else begin
        wr_stb[g] <= hit;
        if (hit) ch_q[g] <= cmd_data;
      end
    end
    assign ch_flat[g*DATA_W +: DATA_W] = ch_q[g];

    a_r6_chan_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_q[g]) |-> wr_stb[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q    <= '0;
      hiz_q    <= 1'b0;
      ctrl_stb <= 1'b0;
    end else begin
      ctrl_stb <= wr_cmd && cmd_addr == A_CTRL;
      if (wr_cmd && cmd_addr == A_CTRL) begin
        pwr_q <= cmd_data[PWR_LSB +: NCH];
        hiz_q <= cmd_data[HIZ_BIT];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == ADDR_W'(i + 1)) rd_word = ch_q[i];
    if (rd_addr == A_CTRL) begin
      rd_word[PWR_LSB +: NCH] = pwr_q;
      rd_word[HIZ_BIT]        = hiz_q;
    end
  end

  a_r4_stb_shape: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '0) |-> ($countones(wr_stb) == 1 || &wr_stb));
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({pwr_q, hiz_q}) |-> ctrl_stb);
  a_r6_stb_exclusive: assert property (@(posedge clk) disable iff (rst)
    ctrl_stb |-> (wr_stb == '0));
endmodule

// File: rtl/spi_dac_regif.sv
module spi_dac_regif #(
  parameter int unsigned NCH    = spi_dac_pkg::DEF_NCH,
  parameter int unsigned ADDR_W = spi_dac_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = spi_dac_pkg::DEF_DATA_W,
  parameter int unsigned SYNC   = spi_dac_pkg::DEF_SYNC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_cs_n,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic [NCH*DATA_W-1:0] ch_data,
  output logic [NCH-1:0]        ch_wr_stb,
  output logic [NCH-1:0]        ctrl_pwr_up,
  output logic                  ctrl_out_hiz,
  output logic                  ctrl_wr_stb
);
  logic [2:0]        pins_s;
  logic [DATA_W-1:0] rd_word, cmd_data;
  logic [ADDR_W-1:0] rd_addr, cmd_addr;
  logic              exec, cmd_rd;

  spi_dac_sync #(.N(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .din({spi_cs_n, spi_sclk, spi_mosi}),
    .dout(pins_s)
  );

  spi_dac_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .exec(exec), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .sdo(spi_miso), .sdo_en(spi_miso_oe)
  );

  spi_dac_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .exec(exec), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .ch_flat(ch_data), .wr_stb(ch_wr_stb),
    .pwr_q(ctrl_pwr_up), .hiz_q(ctrl_out_hiz), .ctrl_stb(ctrl_wr_stb)
  );
endmodule

// File: tb/sim_spi_dac_regif.sv
`timescale 1ns/1ps
module sim_spi_dac_regif;
  localparam int HALF = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, ctrl_hiz, ctrl_stb;
  logic [47:0] ch_data;
  logic [3:0] ch_stb, pwr;

  always #2 clk = ~clk;

  spi_dac_regif u0 (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .ch_data(ch_data),
    .ch_wr_stb(ch_stb), .ctrl_pwr_up(pwr), .ctrl_out_hiz(ctrl_hiz),
    .ctrl_wr_stb(ctrl_stb)
  );

  int checks = 0, fails = 0;
  int stb_n [4];
  int cstb_n = 0;
  logic [11:0] rd_got;
  int oe_bad;
  logic [11:0] m_ch [4];
  logic [3:0] m_pwr;
  logic m_hiz;

  initial for (int i = 0; i < 4; i++) stb_n[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (ch_stb[i]) stb_n[i]++;
    if (ctrl_stb) cstb_n++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nclk clocks; hold keeps select low at the end; cut raises select before the last fall
  task automatic send_frame(input logic [15:0] w, input int nclk, input bit hold, input bit cut);
    rd_got = '0;
    oe_bad = 0;
    cs_n = 1'b0;
    wait_n(HALF);
    for (int k = 1; k <= nclk; k++) begin
      mosi = (k <= 16) ? w[16-k] : 1'b0;
      wait_n(HALF);
      sclk = 1'b1;
      wait_n(HALF);
      if (miso_oe !== (w[15] && k >= 5 && k <= 16)) oe_bad++;
      if (k >= 5 && k <= 16) rd_got[16-k] = miso;
      if (cut && k == nclk) begin
        cs_n = 1'b1;
        wait_n(HALF);
      end
      sclk = 1'b0;
    end
    wait_n(HALF);
    if (!hold) cs_n = 1'b1;
    wait_n(HALF);
  endtask

  function automatic logic [47:0] model_flat();
    return {m_ch[3], m_ch[2], m_ch[1], m_ch[0]};
  endfunction

  function automatic logic [3:0] stb_snapshot_delta(input int b [4]);
    logic [3:0] d;
    for (int i = 0; i < 4; i++) d[i] = (stb_n[i] - b[i]) != 0;
    return d;
  endfunction

  // {frame word, expected channel strobes, expected control strobe}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {16'h1123, 4'b0001, 1'b0},
    {16'h2ABC, 4'b0010, 1'b0},
    {16'h35A5, 4'b0100, 1'b0},
    {16'h4FFF, 4'b1000, 1'b0},
    {16'h0777, 4'b0000, 1'b0},
    {16'h6321, 4'b0000, 1'b0},
    {16'h50F0, 4'b1111, 1'b0},
    {16'h1800, 4'b0001, 1'b0},
    {16'h7054, 4'b0000, 1'b1},
    {16'h4001, 4'b1000, 1'b0}
  };

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base [4];
    int cb;
    int pulses;
    logic [15:0] w;
    logic [2:0] a;
    for (int i = 0; i < 4; i++) m_ch[i] = '0;
    m_pwr = '0; m_hiz = 1'b0;
    wait_n(6);
    rst = 1'b0;
    wait_n(4);
    // R12 reset state
    chk("R12 ch_data", 64'(ch_data), 64'h0);
    chk("R12 ctrl", 64'({pwr, ctrl_hiz}), 64'h0);
    chk("R12 oe/strobes", 64'({miso_oe, ch_stb, ctrl_stb}), 64'h0);

    // R1 R3 R4 R5 R6 table of writes
    for (int v = 0; v < NV; v++) begin
      w = VEC[v][20:5];
      for (int i = 0; i < 4; i++) base[i] = stb_n[i];
      cb = cstb_n;
      send_frame(w, 16, 1'b0, 1'b0);
      a = w[14:12];
      if (a >= 3'd1 && a <= 3'd4) m_ch[a-1] = w[11:0];
      if (a == 3'd5) for (int i = 0; i < 4; i++) m_ch[i] = w[11:0];
      if (a == 3'd7) begin m_pwr = w[5:2]; m_hiz = w[6]; end
      pulses = 0;
      for (int i = 0; i < 4; i++) pulses += stb_n[i] - base[i];
      chk("R1/R3/R6 ch_data", 64'(ch_data), 64'(model_flat()));
      chk("R3/R4/R6 strobes", 64'(stb_snapshot_delta(base)), 64'(VEC[v][4:1]));
      chk("R3/R4 single pulse each", 64'(pulses), 64'($countones(VEC[v][4:1])));
      chk("R5 ctrl strobe", 64'(cstb_n - cb), 64'(VEC[v][0]));
      chk("R5 ctrl flags", 64'({pwr, ctrl_hiz}), 64'({m_pwr, m_hiz}));
      chk("R9 oe low in write", 64'(oe_bad), 64'h0);
    end

    // R8 read of channel A, data bits of the frame must not write
    for (int i = 0; i < 4; i++) base[i] = stb_n[i];
    send_frame(16'h9ABC, 16, 1'b0, 1'b0);
    chk("R8 read A data", 64'(rd_got), 64'h800);
    chk("R8 oe window", 64'(oe_bad), 64'h0);
    chk("R8 no strobe", 64'(stb_snapshot_delta(base)), 64'h0);
    chk("R8 regs unchanged", 64'(ch_data), 64'(model_flat()));
    chk("R9 oe released", 64'(miso_oe), 64'h0);
    send_frame(16'hC000, 16, 1'b0, 1'b0);
    chk("R8 read D data", 64'(rd_got), 64'h001);
    // R5 control readback
    send_frame(16'hF000, 16, 1'b0, 1'b0);
    chk("R5 read ctrl", 64'(rd_got), 64'h054);
    // R10 reads of empty addresses
    send_frame(16'h8FFF, 16, 1'b0, 1'b0);
    chk("R10 read addr0", 64'(rd_got), 64'h0);
    send_frame(16'hD000, 16, 1'b0, 1'b0);
    chk("R10 read addr5", 64'(rd_got), 64'h0);
    send_frame(16'hE000, 16, 1'b0, 1'b0);
    chk("R10 read addr6", 64'(rd_got), 64'h0);
    chk("R10 oe window", 64'(oe_bad), 64'h0);

    // R7 partial frames
    for (int i = 0; i < 4; i++) base[i] = stb_n[i];
    send_frame(16'h13C3, 10, 1'b0, 1'b0);
    chk("R7 short frame", 64'(ch_data), 64'(model_flat()));
    send_frame(16'h13C3, 16, 1'b0, 1'b1);
    chk("R7 cut before last fall", 64'(ch_data), 64'(model_flat()));
    chk("R7 no strobe", 64'(stb_snapshot_delta(base)), 64'h0);

    // R2 execution with select still low
    send_frame(16'h2246, 16, 1'b1, 1'b0);
    m_ch[1] = 12'h246;
    chk("R2 cs low", 64'(cs_n), 64'h0);
    chk("R2 executed before cs rise", 64'(ch_data), 64'(model_flat()));
    // R11 clocks after completion without a new falling edge are ignored
    for (int i = 0; i < 4; i++) base[i] = stb_n[i];
    send_frame(16'h1FFF, 20, 1'b0, 1'b0);
    chk("R11 ignored clocks", 64'(ch_data), 64'(model_flat()));
    chk("R11 no strobe", 64'(stb_snapshot_delta(base)), 64'h0);
    // R11 a fresh frame after select toggles works again
    send_frame(16'h1ABC, 16, 1'b0, 1'b0);
    m_ch[0] = 12'hABC;
    chk("R11 new frame", 64'(ch_data), 64'(model_flat()));
    chk("R9 idle oe", 64'(miso_oe), 64'h0);

    finish_run();
  end
endmodule